// File: doc/BRIEF.md
# Byte String Loader with Compare

This block fetches a run of bytes from ascending addresses, one read per byte, and deposits them into a register file as packed 32-bit words. The first byte lands in the most significant lane of the first register. Each later byte takes the next lane down, and after the least significant lane the walk continues in the next register. The register index wraps within 5 bits. A write touches only its own byte lane, so the other three bytes of the target register keep their contents.

The run stops after the programmed byte count, or earlier if a fetched byte equals a compare value. The matching byte is still deposited. Two register indices can be named as protected; bytes aimed at them are dropped, but the walk still steps past them. On completion the block pulses `done` and presents the number of bytes consumed before the match, or the full count if no match occurred.

Memory reads use a valid/ready request channel and a valid/ready response channel. A request is held with a stable address until `mem_req_ready` is seen high on a clock edge. At most one read is outstanding. The block raises `mem_rsp_ready` only while it waits for the answer to an accepted request, and the memory must not present `mem_rsp_valid` at any other time. In the cycle a response is taken, the register write port fires combinationally.

Top module: `byte_string_loader`

## Requirements
- R1: The first byte is written to bits 31:24 (`rf_be` = 4'b1000) of register `first_reg`; each following byte goes one lane lower (4'b0100, then 4'b0010, then 4'b0001).
- R2: After a byte in bits 7:0, the next byte goes to bits 31:24 of the register whose index is one higher, modulo 32.
- R3: Each register write has exactly one `rf_be` bit set, and `rf_wdata` carries the byte in all four lanes, so only the enabled lane changes.
- R4: No write is issued when the current register equals `prot_b`, or equals `prot_a` while `prot_a` is nonzero; the lane and register walk still advances past the dropped byte. A zero `prot_a` protects nothing.
- R5: A byte equal to `cmp_byte` is still written (unless protected), the run then stops, and `done_cnt` equals the zero-based position of that byte.
- R6: Without a match, exactly `byte_cnt` bytes are read and `done_cnt` equals `byte_cnt`.
- R7: The first read uses `base_addr`, and each later read uses the previous address plus one. With `narrow` high, the sum is cut to its low 32 bits and the upper address bits are zero.
- R8: A start with `byte_cnt` = 0 issues no read and raises `done` on the next clock edge with `done_cnt` = 0.
- R9: `mem_req_valid` with its address stays stable until accepted, at most one read is outstanding, and each register write coincides with an accepted response.
- R10: `done` is a single-cycle pulse with `done_cnt` valid during it; `busy` is high from start to completion; a `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| narrow | input | 1 | 32-bit address wrap mode |
| base_addr | input | ADDR_W | Address of the first byte |
| byte_cnt | input | CNT_W | Number of bytes to load |
| cmp_byte | input | 8 | Stop byte |
| first_reg | input | 5 | First destination register |
| prot_a | input | 5 | Protected index, active only when nonzero |
| prot_b | input | 5 | Protected index, always active |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block waits for read data |
| mem_rsp_data | input | 8 | Read data byte |
| rf_we | output | 1 | Register write strobe |
| rf_idx | output | 5 | Register index |
| rf_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| rf_wdata | output | 32 | Byte replicated in all lanes |
| busy | output | 1 | Run in progress |
| done | output | 1 | Completion pulse |
| done_cnt | output | CNT_W | Bytes consumed before stop |

## Verification
Runs are tried with a short unmatched string starting mid-file, a string whose register walk crosses index 31 back to 0, and strings that meet the stop byte at position zero and in the middle. These separate lane ordering, index wrap and the off-by-one in the returned count. Protected indices at the first and second destination register, and a zero `prot_a` aimed at register 0, distinguish dropping a byte from stalling the walk. A start near the 32-bit boundary is run in both address modes to tell the wrap apart from a carry into the upper bits. Zero-length, maximum-length and start-while-busy cases round out the set, all under an irregular memory ready pattern.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } bsl_state_e;
endpackage

// File: rtl/bsl_addr_step.sv
module bsl_addr_step #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              narrow,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] inc;
  assign inc = cur + {{(ADDR_W-1){1'b0}}, 1'b1};

  generate
    if (ADDR_W > 32) begin : g_wide
      assign nxt = narrow ? {{(ADDR_W-32){1'b0}}, inc[31:0]} : inc;
    end else begin : g_flat
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign nxt = inc;
    end
  endgenerate
endmodule

// File: rtl/bsl_lane_writer.sv
module bsl_lane_writer #(
  parameter int LANES = 4,
  parameter int REG_W = 5,
  localparam int LANE_W = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input  logic              fire,
  input  logic [LANE_W-1:0] lane,
  input  logic [REG_W-1:0]  reg_idx,
  input  logic [REG_W-1:0]  prot_a,
  input  logic [REG_W-1:0]  prot_b,
  input  logic [7:0]        byte_in,
  output logic              we,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  logic blocked;
  assign blocked = (reg_idx == prot_b) ||
                   ((prot_a != '0) && (reg_idx == prot_a));
  assign we = fire && !blocked;

  // lane 0 is the most significant byte, so it maps to the top enable bit
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = (lane == LANE_W'(LANES - 1 - g));
    assign wdata[g*8 +: 8] = byte_in;
  end
endmodule

// File: rtl/byte_string_loader.sv
module byte_string_loader
  import bsl_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 7,
  parameter int REG_W  = 5,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              narrow,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [7:0]        cmp_byte,
  input  logic [REG_W-1:0]  first_reg,
  input  logic [REG_W-1:0]  prot_a,
  input  logic [REG_W-1:0]  prot_b,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [7:0]        mem_rsp_data,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_idx,
  output logic [LANES-1:0]  rf_be,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  done_cnt
);
  bsl_state_e        state_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [CNT_W-1:0]  idx_q, cnt_q, done_cnt_q;
  logic [LANE_W-1:0] lane_q;
  logic [REG_W-1:0]  reg_q, pa_q, pb_q;
  logic [7:0]        cmp_q;
  logic              narrow_q, done_q;

  logic take, hit, last;
  assign take = (state_q == S_WAIT) && mem_rsp_valid;
  assign hit  = (mem_rsp_data == cmp_q);
  assign last = ({1'b0, idx_q} + {{CNT_W{1'b0}}, 1'b1}) == {1'b0, cnt_q};

  bsl_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur    (addr_q),
    .narrow (narrow_q),
    .nxt    (addr_nxt)
  );

  bsl_lane_writer #(.LANES(LANES), .REG_W(REG_W)) u_lane (
    .fire    (take),
    .lane    (lane_q),
    .reg_idx (reg_q),
    .prot_a  (pa_q),
    .prot_b  (pb_q),
    .byte_in (mem_rsp_data),
    .we      (rf_we),
    .be      (rf_be),
    .wdata   (rf_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      idx_q      <= '0;
      cnt_q      <= '0;
      lane_q     <= '0;
      reg_q      <= '0;
      pa_q       <= '0;
      pb_q       <= '0;
      cmp_q      <= '0;
      narrow_q   <= 1'b0;
      done_q     <= 1'b0;
      done_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            addr_q   <= base_addr;
            cnt_q    <= byte_cnt;
            cmp_q    <= cmp_byte;
            reg_q    <= first_reg;
            pa_q     <= prot_a;
            pb_q     <= prot_b;
            narrow_q <= narrow;
            idx_q    <= '0;
            lane_q   <= '0;
            if (byte_cnt == '0) begin
              done_q     <= 1'b1;
              done_cnt_q <= '0;
            end else begin
              state_q <= S_REQ;
            end
          end
        end
        S_REQ: begin
          if (mem_req_ready) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (hit || last) begin
              state_q    <= S_IDLE;
              done_q     <= 1'b1;
              done_cnt_q <= hit ? idx_q : cnt_q;
            end else begin
              state_q <= S_REQ;
              idx_q   <= idx_q + {{(CNT_W-1){1'b0}}, 1'b1};
              addr_q  <= addr_nxt;
              lane_q  <= lane_q + {{(LANE_W-1){1'b0}}, 1'b1};
              if (lane_q == LANE_W'(LANES - 1))
                reg_q <= reg_q + {{(REG_W-1){1'b0}}, 1'b1};
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == S_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (state_q == S_WAIT);
  assign rf_idx        = reg_q;
  assign busy          = (state_q != S_IDLE);
  assign done          = done_q;
  assign done_cnt      = done_cnt_q;
endmodule

// File: rtl/bsl_checks.sv
module bsl_checks #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 7,
  parameter int REG_W  = 5,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic [REG_W-1:0]  prot_a,
  input logic [REG_W-1:0]  prot_b,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic              rf_we,
  input logic [REG_W-1:0]  rf_idx,
  input logic [LANES-1:0]  rf_be,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  done_cnt
);
  p_lane_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ($countones(rf_be) == 1));

  p_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ((rf_idx != prot_b) && !((prot_a != '0) && (rf_idx == prot_a))));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  p_write_on_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_rsp_valid && mem_rsp_ready));

  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (byte_cnt == '0)) |=> (done && (done_cnt == '0) && !mem_req_valid));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind byte_string_loader bsl_checks #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
  .prot_a(prot_a), .prot_b(prot_b),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_ready(mem_rsp_ready), .rf_we(rf_we), .rf_idx(rf_idx),
  .rf_be(rf_be), .busy(busy), .done(done), .done_cnt(done_cnt)
);

// File: tb/sim_byte_string_loader.sv
`timescale 1ns/1ps
module sim_byte_string_loader;
  localparam int AW = 64;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          narrow = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic [7:0]    cmp_byte = '0;
  logic [4:0]    first_reg = '0;
  logic [4:0]    prot_a = '0;
  logic [4:0]    prot_b = 5'd20;
  logic          mem_req_valid, mem_rsp_ready;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [7:0]    mem_rsp_data = '0;
  logic          rf_we;
  logic [4:0]    rf_idx;
  logic [3:0]    rf_be;
  logic [31:0]   rf_wdata;
  logic          busy, done;
  logic [CW-1:0] done_cnt;

  always #2 clk = ~clk;

  byte_string_loader u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .narrow(narrow),
    .base_addr(base_addr), .byte_cnt(byte_cnt), .cmp_byte(cmp_byte),
    .first_reg(first_reg), .prot_a(prot_a), .prot_b(prot_b),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_be(rf_be), .rf_wdata(rf_wdata),
    .busy(busy), .done(done), .done_cnt(done_cnt)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [AW-1:0] exp_addr[$];
  logic [16:0]   exp_wr[$];   // {idx[4:0], be[3:0], byte[7:0]}

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
    return a[7:0] + a[39:32] + 8'h30;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and write monitor, both driven from the falling edge
  int cyc = 0;
  bit will_hs = 1'b0;
  logic [AW-1:0] hs_addr = '0;
  localparam logic [7:0] RDY_PAT = 8'b1011_0110;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (will_hs) begin
        if (exp_addr.size() == 0) begin
          chk(1'b0, "R6 R9 unexpected read", hs_addr, 0);
        end else begin
          logic [AW-1:0] ea;
          ea = exp_addr.pop_front();
          chk(hs_addr == ea, "R7 read address", hs_addr, ea);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_byte(hs_addr);
      end else begin
        mem_rsp_valid = 1'b0;
      end
      mem_req_ready = RDY_PAT[cyc % 8];
      #1;
      will_hs = mem_req_valid && mem_req_ready;
      hs_addr = mem_req_addr;
      if (rf_we) begin
        if (exp_wr.size() == 0) begin
          chk(1'b0, "R4 R5 unexpected write", {rf_idx, rf_be}, 0);
        end else begin
          logic [16:0] ew;
          ew = exp_wr.pop_front();
          chk(rf_idx == ew[16:12], "R2 R4 write index", rf_idx, ew[16:12]);
          chk(rf_be == ew[11:8], "R1 R3 byte enable", rf_be, ew[11:8]);
          chk(rf_wdata == {4{ew[7:0]}}, "R3 write data", rf_wdata, {4{ew[7:0]}});
        end
      end
    end
  end

  // driver: builds the expected reads and writes, then runs one string load
  task automatic run_op(logic [AW-1:0] base, bit nar, int cnt, logic [7:0] cmp,
                        logic [4:0] fr, logic [4:0] pa, logic [4:0] pb,
                        bit poke, string tag);
    logic [AW-1:0] a;
    logic [4:0] r;
    int lane, expc, waited;
    a = base; r = fr; lane = 0; expc = cnt;
    for (int i = 0; i < cnt; i++) begin
      logic [7:0] b;
      b = mem_byte(a);
      exp_addr.push_back(a);
      if (!(r == pb || (pa != 0 && r == pa)))
        exp_wr.push_back({r, 4'(4'b1000 >> lane), b});
      if (b == cmp) begin
        expc = i;
        break;
      end
      a = a + 1;
      if (nar) a = {32'b0, a[31:0]};
      if (lane == 3) begin lane = 0; r = r + 5'd1; end
      else lane++;
    end
    base_addr = base; narrow = nar; byte_cnt = CW'(cnt); cmp_byte = cmp;
    first_reg = fr; prot_a = pa; prot_b = pb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    if (poke) begin
      // R10: start while busy with different settings is ignored
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R10 busy during run", busy, 1);
      base_addr = base + 64'h100; byte_cnt = 7'd2; cmp_byte = ~cmp; first_reg = fr + 5'd7;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, {tag, " R10 done seen"}, done, 1);
    chk(done_cnt == CW'(expc), {tag, " R5 R6 done count"}, done_cnt, expc);
    chk(exp_addr.size() == 0, {tag, " R6 R9 reads outstanding"}, exp_addr.size(), 0);
    chk(exp_wr.size() == 0, {tag, " R4 writes outstanding"}, exp_wr.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R10 done pulse width"}, done, 0);
    chk(busy == 1'b0, {tag, " R10 idle after done"}, busy, 0);
    exp_addr.delete();
    exp_wr.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 reset idle", {busy, done}, 0);
    chk(mem_req_valid == 1'b0 && rf_we == 1'b0, "R9 reset quiet", {mem_req_valid, rf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: zero length
    byte_cnt = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R8 done after one edge", done, 1);
    chk(done_cnt == '0, "R8 zero count", done_cnt, 0);
    chk(mem_req_valid == 1'b0, "R8 no read", mem_req_valid, 0);
    @(negedge clk);

    // R1 R6: unmatched run starting mid-file
    run_op(64'h0000_0000_0000_1000, 1'b0, 10, 8'h00, 5'd3, 5'd0, 5'd20, 1'b0, "plain");
    // R2: register walk wraps past 31
    run_op(64'h0000_0000_0000_2040, 1'b0, 9, 8'h00, 5'd30, 5'd0, 5'd20, 1'b0, "regwrap");
    // R4: protected first and second register
    run_op(64'h0000_0000_0000_3000, 1'b0, 12, 8'h00, 5'd5, 5'd6, 5'd5, 1'b0, "protect");
    // R4: zero prot_a does not protect register 0
    run_op(64'h0000_0000_0000_3100, 1'b0, 5, 8'h00, 5'd0, 5'd0, 5'd9, 1'b0, "ra_zero");
    // R5: match in the middle (position 5) and at position 0
    run_op(64'h0000_0000_0000_4000, 1'b0, 20, mem_byte(64'h4005), 5'd1, 5'd0, 5'd20, 1'b0, "mid_match");
    run_op(64'h0000_0000_0000_4200, 1'b0, 20, mem_byte(64'h4200), 5'd8, 5'd0, 5'd20, 1'b0, "first_match");
    // R7: 32-bit wrap versus full carry
    run_op(64'h0000_0001_FFFF_FFFE, 1'b1, 6, 8'hEE, 5'd2, 5'd0, 5'd20, 1'b0, "narrow");
    run_op(64'h0000_0001_FFFF_FFFE, 1'b0, 6, 8'hEE, 5'd2, 5'd0, 5'd20, 1'b0, "wide");
    // R6: maximum length, no match
    run_op(64'h0000_0000_0000_5000, 1'b0, 127, mem_byte(64'h4FFF), 5'd4, 5'd0, 5'd31, 1'b0, "maxlen");
    // R10: start while busy ignored
    run_op(64'h0000_0000_0000_6000, 1'b0, 8, 8'h00, 5'd10, 5'd0, 5'd20, 1'b1, "busy_start");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=busy expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule